// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This block sits beside an 8-bit CPU core and decides which of seven interrupt sources the core services next. Software programs it through a byte-wide register bus. One register holds a global enable and one enable bit per source. Two further registers each give every source one bit, and together the two bits set that source's priority to one of four levels. A small mode register picks, for each of the two external pins, whether a falling edge or a low level raises a request.

On each cycle the controller looks at the enabled, pending sources and keeps only those whose level is strictly above every level already in service. From those it takes the highest level, and on a tie the source that comes first in a fixed polling order. It holds a request toward the core, together with the source's vector address and index, until the core acknowledges. The acknowledge marks that level as in service. It also fires a clear strobe for the two timer overflow flags, and drops the latched flag of an external pin that is in edge mode. A return pulse from the core retires the highest level in service, so a handler that was preempted becomes the active one again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable, low-priority, high-priority and mode registers read zero. They are written and read back at addresses 0xA8 (enable), 0xB8 (low priority bits), 0xB7 (high priority bits) and 0xC0 (mode, bit 0 = external 0 edge mode, bit 1 = external 1 edge mode). Any other address reads zero.
- R2: Source index and register bit position: external 0 is index 0, bit 0. Timer 0 is index 1, bit 1. External 1 is index 2, bit 2. Timer 1 is index 3, bit 3. Capture/compare unit is index 4, bit 6. Serial port is index 5, bit 4. Timer 2 is index 6, bit 5. A source can raise a request only when both its enable bit and enable bit 7 (global) are 1.
- R3: A source's level is {high bit, low bit}, where 3 is the highest. The highest-level eligible source wins.
- R4: Among eligible sources at the same level, the lowest source index wins.
- R5: The vector output is 0x03, 0x0B, 0x13, 0x1B, 0x33, 0x23 or 0x2B for source index 0 to 6 in turn.
- R6: Once raised, the request output stays high with a stable vector and source until the core acknowledges.
- R7: An acknowledge drops the request and marks the winner's level in service. No source at a level equal to or below the highest level in service is requested.
- R8: A source at a level above every in-service level is requested even while a handler is active. A return pulse retires only the highest in-service level, so lower-level sources become eligible again only after the matching returns.
- R9: Acknowledging timer 0 or timer 1 pulses that timer's clear output during the acknowledge cycle. No other acknowledge pulses them.
- R10: In edge mode, a falling edge on an external pin (seen after a two-flop synchronizer) latches its flag until that source is acknowledged. In level mode the flag follows the low pin and is not cleared by acknowledge.
- R11: The capture/compare, serial and timer 2 requests are never cleared by the block. One still pending after its handler returns is requested again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 8 | Register bus address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| ext0_ni | input | 1 | External interrupt pin 0, active low |
| ext1_ni | input | 1 | External interrupt pin 1, active low |
| tmr0_flag_i | input | 1 | Timer 0 overflow flag |
| tmr1_flag_i | input | 1 | Timer 1 overflow flag |
| ccu_flag_i | input | 1 | Combined capture/compare unit flags |
| ser_flag_i | input | 1 | Combined serial receive/transmit flags |
| tmr2_flag_i | input | 1 | Combined timer 2 flags |
| irq_ack_i | input | 1 | Core acknowledge of the held request |
| irq_ret_i | input | 1 | Core return-from-interrupt pulse |
| irq_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 8 | Vector address of the held request |
| irq_src_o | output | 3 | Source index of the held request |
| tmr0_clr_o | output | 1 | Clear strobe for the timer 0 flag |
| tmr1_clr_o | output | 1 | Clear strobe for the timer 1 flag |
| ext_flag_o | output | 2 | Internal request flags of external 1 and 0 |

## Verification
On every cycle the assertions check four things: a held request keeps its source until acknowledged, a held request is always above the in-service level, an acknowledge drops the request and sets its level in service, and a return retires exactly one level. They also check that a new request never starts while the global enable is off, and that a synchronized falling edge in edge mode latches the flag. The bench scenarios cover what needs a chosen stimulus sequence. These are the bit mapping of enables and priorities, tie-breaking by polling order, each vector value, a full preempt-and-return nesting run, timer clear strobes against untouched serial flags, and the contrast between edge and level handling on the external pins.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned NSRC = 7;
  localparam int unsigned SRCW = 3;
  localparam int unsigned LVLW = 2;
  localparam int unsigned NLVL = 1 << LVLW;
  localparam int unsigned NEXT = 2;

  typedef enum logic [SRCW-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_CCU  = 3'd4,
    SRC_SER  = 3'd5,
    SRC_TMR2 = 3'd6
  } src_e;

  // Bit position of a source inside the enable and priority registers
  function automatic int unsigned reg_bit(int unsigned s);
    case (s)
      4:       return 6;
      5:       return 4;
      6:       return 5;
      default: return s;
    endcase
  endfunction

  function automatic logic [7:0] vec_of(logic [SRCW-1:0] s);
    case (s)
      3'd0:    return 8'h03;
      3'd1:    return 8'h0B;
      3'd2:    return 8'h13;
      3'd3:    return 8'h1B;
      3'd4:    return 8'h33;
      3'd5:    return 8'h23;
      default: return 8'h2B;
    endcase
  endfunction
endpackage

// File: rtl/irq_ext_detect.sv
module irq_ext_detect #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic flag_o
);
  logic [SYNC-1:0] sync_q;
  logic            last_q;
  logic            edge_q;
  logic            fall;

  assign fall = last_q & ~sync_q[SYNC-1];

  // Synchronizer resets to the idle (high) pin state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
      edge_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin_ni};
      last_q <= sync_q[SYNC-1];
      if (!edge_mode_i)   edge_q <= 1'b0;
      else if (fall)      edge_q <= 1'b1;
      else if (clr_i)     edge_q <= 1'b0;
    end
  end

  assign flag_o = edge_mode_i ? edge_q : ~sync_q[SYNC-1];

  p_edge_latch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && fall) |=> (flag_o || !edge_mode_i));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
(
  input  logic [NSRC-1:0]           req_i,
  input  logic [NSRC-1:0][LVLW-1:0] lvl_i,
  input  logic [LVLW:0]             floor_i,
  output logic                      valid_o,
  output logic [SRCW-1:0]           src_o,
  output logic [LVLW-1:0]           lvl_o
);
  // Descending scan with >= so the lowest index wins a tie
  always_comb begin
    valid_o = 1'b0;
    src_o   = '0;
    lvl_o   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i] && (({1'b0, lvl_i[i]} + 1'b1) > floor_i) &&
          (!valid_o || lvl_i[i] >= lvl_o)) begin
        valid_o = 1'b1;
        src_o   = SRCW'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest
  import prio_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [LVLW-1:0] set_lvl_i,
  input  logic            pop_i,
  output logic [LVLW:0]   floor_o
);
  logic [NLVL-1:0] isr_q, isr_d, top_oh;

  always_comb begin
    floor_o = '0;
    top_oh  = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (isr_q[l]) begin
        floor_o = (LVLW+1)'(l + 1);
        top_oh  = NLVL'(1) << l;
      end
    end
  end

  always_comb begin
    isr_d = isr_q;
    if (pop_i) isr_d = isr_d & ~top_oh;
    if (set_i) isr_d[set_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  p_set_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> isr_q[$past(set_lvl_i)]);

  p_pop_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !set_i && isr_q != '0) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter logic [7:0] ADDR_EN   = 8'hA8,
  parameter logic [7:0] ADDR_PLO  = 8'hB8,
  parameter logic [7:0] ADDR_PHI  = 8'hB7,
  parameter logic [7:0] ADDR_MODE = 8'hC0,
  parameter int unsigned SYNC     = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [7:0]      reg_addr_i,
  input  logic            reg_wr_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [7:0]      reg_rdata_o,
  input  logic            ext0_ni,
  input  logic            ext1_ni,
  input  logic            tmr0_flag_i,
  input  logic            tmr1_flag_i,
  input  logic            ccu_flag_i,
  input  logic            ser_flag_i,
  input  logic            tmr2_flag_i,
  input  logic            irq_ack_i,
  input  logic            irq_ret_i,
  output logic            irq_o,
  output logic [7:0]      irq_vec_o,
  output logic [SRCW-1:0] irq_src_o,
  output logic            tmr0_clr_o,
  output logic            tmr1_clr_o,
  output logic [NEXT-1:0] ext_flag_o
);
  localparam int unsigned GLOBAL_BIT = 7;

  logic [7:0]      en_q, plo_q, phi_q;
  logic [NEXT-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      plo_q  <= '0;
      phi_q  <= '0;
      mode_q <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        ADDR_EN:   en_q   <= reg_wdata_i;
        ADDR_PLO:  plo_q  <= reg_wdata_i;
        ADDR_PHI:  phi_q  <= reg_wdata_i;
        ADDR_MODE: mode_q <= reg_wdata_i[NEXT-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_EN:   reg_rdata_o = en_q;
      ADDR_PLO:  reg_rdata_o = plo_q;
      ADDR_PHI:  reg_rdata_o = phi_q;
      ADDR_MODE: reg_rdata_o = {{(8-NEXT){1'b0}}, mode_q};
      default:   reg_rdata_o = '0;
    endcase
  end

  // Held request
  logic            irq_q;
  logic [SRCW-1:0] src_q;
  logic [LVLW-1:0] lvl_q;
  logic            ack_fire;

  assign ack_fire = irq_ack_i & irq_q;

  // External pins
  logic [NEXT-1:0] ext_pin_n;
  assign ext_pin_n = {ext1_ni, ext0_ni};

  for (genvar e = 0; e < NEXT; e++) begin : g_ext
    localparam logic [SRCW-1:0] SRC_IDX = SRCW'(2 * e);
    logic clr;
    assign clr = ack_fire && (src_q == SRC_IDX) && mode_q[e];
    irq_ext_detect #(.SYNC(SYNC)) u_det (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pin_ni      (ext_pin_n[e]),
      .edge_mode_i (mode_q[e]),
      .clr_i       (clr),
      .flag_o      (ext_flag_o[e])
    );
  end

  logic [NSRC-1:0]           raw_req, req;
  logic [NSRC-1:0][LVLW-1:0] lvl;

  assign raw_req = {tmr2_flag_i, ser_flag_i, ccu_flag_i, tmr1_flag_i,
                    ext_flag_o[1], tmr0_flag_i, ext_flag_o[0]};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int unsigned B = reg_bit(s);
    assign req[s] = raw_req[s] & en_q[B] & en_q[GLOBAL_BIT];
    assign lvl[s] = {phi_q[B], plo_q[B]};
  end

  logic [LVLW:0]   floor;
  logic            win_valid;
  logic [SRCW-1:0] win_src;
  logic [LVLW-1:0] win_lvl;

  irq_arbiter u_arb (
    .req_i   (req),
    .lvl_i   (lvl),
    .floor_i (floor),
    .valid_o (win_valid),
    .src_o   (win_src),
    .lvl_o   (win_lvl)
  );

  irq_nest u_nest (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (ack_fire),
    .set_lvl_i (lvl_q),
    .pop_i     (irq_ret_i),
    .floor_o   (floor)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      src_q <= '0;
      lvl_q <= '0;
    end else if (ack_fire) begin
      irq_q <= 1'b0;
    end else if (!irq_q && win_valid) begin
      irq_q <= 1'b1;
      src_q <= win_src;
      lvl_q <= win_lvl;
    end
  end

  assign irq_o      = irq_q;
  assign irq_src_o  = src_q;
  assign irq_vec_o  = vec_of(src_q);
  assign tmr0_clr_o = ack_fire && (src_q == SRC_TMR0);
  assign tmr1_clr_o = ack_fire && (src_q == SRC_TMR1);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_ack_i) |=> (irq_q && $stable(src_q)));

  p_above_isr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (({1'b0, lvl_q} + 1'b1) > floor));

  p_ack_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire |=> !irq_q);

  p_global_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(en_q[GLOBAL_BIT]));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext0_n = 1'b1, ext1_n = 1'b1;
  logic       tmr0_f = 0, tmr1_f = 0, ccu_f = 0, ser_f = 0, tmr2_f = 0;
  logic       ack = 0, ret = 0;
  logic       irq;
  logic [7:0] vec;
  logic [2:0] src;
  logic       tmr0_clr, tmr1_clr;
  logic [1:0] ext_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .ext0_ni(ext0_n), .ext1_ni(ext1_n),
    .tmr0_flag_i(tmr0_f), .tmr1_flag_i(tmr1_f), .ccu_flag_i(ccu_f),
    .ser_flag_i(ser_f), .tmr2_flag_i(tmr2_f),
    .irq_ack_i(ack), .irq_ret_i(ret),
    .irq_o(irq), .irq_vec_o(vec), .irq_src_o(src),
    .tmr0_clr_o(tmr0_clr), .tmr1_clr_o(tmr1_clr), .ext_flag_o(ext_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    {tmr0_f, tmr1_f, ccu_f, ser_f, tmr2_f, ack, ret, reg_wr} = '0;
    ext0_n = 1'b1; ext1_n = 1'b1;
    rst_ni = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(2);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic ack_pulse(output logic c0, output logic c1);
    ack = 1'b1;
    #1;
    c0 = tmr0_clr; c1 = tmr1_clr;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic ret_pulse();
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
  endtask

  task automatic chk_irq(input logic [7:0] exp_vec, input string req);
    chk(irq == 1'b1, req, irq, 1);
    chk(vec == exp_vec, req, vec, exp_vec);
  endtask

  task automatic t_reset_regs();
    do_reset();
    chk(irq == 1'b0, "R1 irq idle", irq, 0);
    rd_chk(8'hA8, 8'h00, "R1 reset enable");
    rd_chk(8'hB8, 8'h00, "R1 reset prio low");
    rd_chk(8'hB7, 8'h00, "R1 reset prio high");
    rd_chk(8'hC0, 8'h00, "R1 reset mode");
    wr(8'hA8, 8'h5A); wr(8'hB8, 8'hA5); wr(8'hB7, 8'h3C); wr(8'hC0, 8'h03);
    wr(8'h42, 8'hFF);
    rd_chk(8'hA8, 8'h5A, "R1 enable readback");
    rd_chk(8'hB8, 8'hA5, "R1 prio low readback");
    rd_chk(8'hB7, 8'h3C, "R1 prio high readback");
    rd_chk(8'hC0, 8'h03, "R1 mode readback");
    rd_chk(8'h42, 8'h00, "R1 unmapped reads zero");
  endtask

  task automatic t_mask();
    do_reset();
    ser_f = 1'b1;
    wr(8'hA8, 8'h10);
    cyc(4);
    chk(irq == 1'b0, "R2 global enable off", irq, 0);
    wr(8'hA8, 8'h88);
    cyc(4);
    chk(irq == 1'b0, "R2 serial bit clear", irq, 0);
    wr(8'hA8, 8'h90);
    cyc(3);
    chk_irq(8'h23, "R5 serial vector");
    chk(src == 3'd5, "R2 serial index", src, 5);
    do_reset();
    tmr2_f = 1'b1;
    wr(8'hA8, 8'hA0);
    cyc(3);
    chk_irq(8'h2B, "R5 timer2 vector");
  endtask

  task automatic t_level();
    do_reset();
    wr(8'hB8, 8'h10); wr(8'hB7, 8'h10);
    tmr0_f = 1'b1; ser_f = 1'b1; tmr1_f = 1'b1;
    wr(8'hA8, 8'hFF);
    cyc(3);
    chk_irq(8'h23, "R3 level 3 serial beats level 0");
  endtask

  task automatic t_polling();
    do_reset();
    tmr1_f = 1'b1; ser_f = 1'b1; tmr2_f = 1'b1;
    wr(8'hA8, 8'hFF);
    cyc(3);
    chk_irq(8'h1B, "R4 timer1 first at level 0");
    do_reset();
    wr(8'hB7, 8'h30);
    tmr1_f = 1'b1; ser_f = 1'b1; tmr2_f = 1'b1;
    wr(8'hA8, 8'hFF);
    cyc(3);
    chk_irq(8'h23, "R4 serial before timer2 at level 2");
  endtask

  task automatic t_nest();
    logic c0, c1;
    do_reset();
    wr(8'hB8, 8'h12); wr(8'hB7, 8'h40);
    wr(8'hA8, 8'hD2);
    tmr0_f = 1'b1;
    cyc(3);
    chk_irq(8'h0B, "R5 timer0 vector");
    ack_pulse(c0, c1);
    chk(c0 == 1'b1, "R9 timer0 clear on ack", c0, 1);
    chk(c1 == 1'b0, "R9 timer1 clear quiet", c1, 0);
    chk(irq == 1'b0, "R7 request dropped on ack", irq, 0);
    tmr0_f = 1'b0;
    ser_f = 1'b1;
    cyc(4);
    chk(irq == 1'b0, "R7 equal level blocked", irq, 0);
    ccu_f = 1'b1;
    cyc(3);
    chk_irq(8'h33, "R8 higher level preempts");
    ack_pulse(c0, c1);
    ccu_f = 1'b0;
    ret_pulse();
    cyc(3);
    chk(irq == 1'b0, "R8 one return keeps level 1 busy", irq, 0);
    ret_pulse();
    cyc(3);
    chk_irq(8'h23, "R8 serial after both returns");
    ack_pulse(c0, c1);
    chk(c0 == 1'b0 && c1 == 1'b0, "R11 no clear strobe for serial", {c1, c0}, 0);
    cyc(3);
    chk(irq == 1'b0, "R7 serial in service blocks itself", irq, 0);
    ret_pulse();
    cyc(3);
    chk_irq(8'h23, "R11 serial flag persists");
  endtask

  task automatic t_tmr1_clear();
    logic c0, c1;
    do_reset();
    tmr1_f = 1'b1;
    wr(8'hA8, 8'h88);
    cyc(3);
    chk_irq(8'h1B, "R5 timer1 vector");
    ack_pulse(c0, c1);
    chk(c1 == 1'b1 && c0 == 1'b0, "R9 timer1 clear on ack", {c1, c0}, 2);
  endtask

  task automatic t_ext_edge();
    logic c0, c1;
    do_reset();
    wr(8'hC0, 8'h01);
    wr(8'hA8, 8'h81);
    ext0_n = 1'b0;
    cyc(2);
    ext0_n = 1'b1;
    cyc(4);
    chk(ext_flag[0] == 1'b1, "R10 edge latched after pin rises", ext_flag[0], 1);
    chk_irq(8'h03, "R5 external0 vector");
    ack_pulse(c0, c1);
    chk(ext_flag[0] == 1'b0, "R10 edge flag cleared by ack", ext_flag[0], 0);
  endtask

  task automatic t_ext_level();
    logic c0, c1;
    do_reset();
    wr(8'hA8, 8'h84);
    ext1_n = 1'b0;
    cyc(4);
    chk_irq(8'h13, "R10 level request external1");
    chk(src == 3'd2, "R2 external1 index", src, 2);
    ack_pulse(c0, c1);
    cyc(2);
    chk(ext_flag[1] == 1'b1, "R10 level flag not cleared", ext_flag[1], 1);
    ext1_n = 1'b1;
    cyc(3);
    chk(ext_flag[1] == 1'b0, "R10 level flag follows pin", ext_flag[1], 0);
  endtask

  initial begin
    t_reset_regs();
    t_mask();
    t_level();
    t_polling();
    t_nest();
    t_tmr1_clear();
    t_ext_edge();
    t_ext_level();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule